// File: doc/BRIEF.md
# Transceiver Control Register Bank with Set/Clear Aliases

This block holds the control and status registers of a USB transceiver. They are reached through a plain 8-bit address/data access port. Each writable control register occupies three consecutive addresses. The base address replaces the whole byte. The next address ORs the written bits in. The third address clears the bits written as 1. A read from any of the three addresses returns the same stored value. The control registers drive their current contents onto output ports, where the transceiver logic uses them.

The bank also holds the read-only identification bytes, a live view of five interrupt sources, a line-state debug byte and an interrupt latch. A latch bit is captured on an enabled rising or falling edge of its source. The latch clears itself when it is read. Function control bit 5 is a transceiver reset request. Setting it leaves the other registers unchanged. The bit clears itself when the transceiver signals that the reset has finished.

The port carries the full 8-bit extended address. Addresses 0x00 to 0x3F are the immediate set. Everything that is not implemented reads as zero, and writes to it are discarded.

Top module: `phyreg_bank`

## Requirements
- R1: Addresses 0x00, 0x01, 0x02 and 0x03 return, in that order, the vendor identifier low byte, the vendor identifier high byte, the product identifier low byte and the product identifier high byte. Writes to these addresses change nothing.
- R2: The six control registers sit at these base addresses: function 0x04, interface 0x07, OTG 0x0A, rising enable 0x0D, falling enable 0x10 and scratch 0x16. A write to the base stores the data. A write to base+1 ORs the data in. A write to base+2 clears the bits that are 1 in the data. A read of base, base+1 or base+2 returns the stored value.
- R3: After reset the registers hold these values: function 0x41, interface 0x00, OTG 0x06, rising enable 0x1F, falling enable 0x1F and scratch 0x00. Function bit 7 and enable bits 7:5 are reserved and always read 0.
- R4: Address 0x13 returns the live source levels, zero-extended. Bit 0 is host disconnect, bit 1 VBUS valid, bit 2 session valid, bit 3 session end and bit 4 ID ground.
- R5: A latch bit is set when its source goes 0 to 1 while its rising-enable bit is 1, or when its source goes 1 to 0 while its falling-enable bit is 1. An edge whose enable bit is 0 does not set the latch bit.
- R6: A read of 0x14 returns the latch and then clears it. An edge event in the same cycle as that read stays latched.
- R7: Address 0x15 returns the two line-state inputs in bits 1:0, with bits 7:2 read as zero.
- R8: Function bit 5 is the reset request. It stays set until `xcvr_rst_done` is sampled high, which clears only that bit. A write that sets the bit in the same cycle wins. No other register is changed.
- R9: Addresses 0x19 to 0x3F (including the extended-access indicator 0x2F) and 0x40 to 0xFF read 0x00. Writes to them are discarded.
- R10: Read data and `acc_rvalid` appear on the clock edge after the clock edge that accepted the read. A control output shows a write on the clock edge that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Access strobe, one access per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Extended register address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Registered read data |
| acc_rvalid | output | 1 | Read data valid |
| irq_src | input | 5 | Interrupt source levels |
| line_state | input | 2 | Line-state signals |
| xcvr_rst_done | input | 1 | Transceiver reset finished |
| func_ctrl_o | output | 8 | Function control contents |
| iface_ctrl_o | output | 8 | Interface control contents |
| otg_ctrl_o | output | 8 | OTG control contents |

## Verification
The hardest case to reach is a source edge that lands in the same cycle as a read of the latch. The read must return the old contents, and the new edge must still be latched afterwards. To reach it, the bench drives the source change and the latch read strobe on the same falling clock edge, so both are seen at one rising edge. It then reads the latch a second time to show that the event is still there. A second hard case is the reset request, because only the completion input clears it. The bench raises the request through the set alias, pulses the completion input, and then reads the other registers back to confirm that none of them changed.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;
   localparam int DW = 8;
   localparam int AW = 8;
   localparam int N_CTRL = 6;

   localparam int IDX_FUNC  = 0;
   localparam int IDX_IFACE = 1;
   localparam int IDX_OTG   = 2;
   localparam int IDX_RISE  = 3;
   localparam int IDX_FALL  = 4;
   localparam int IDX_SCR   = 5;

   localparam logic [AW-1:0] A_STATUS = 8'h13;
   localparam logic [AW-1:0] A_LATCH  = 8'h14;
   localparam logic [AW-1:0] A_DEBUG  = 8'h15;

   localparam int RSTREQ_BIT = 5;

   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_SET   = 2'd1,
      OP_CLEAR = 2'd2,
      OP_NONE  = 2'd3
   } alias_op_e;

   function automatic logic [AW-1:0] ctrl_base(input int idx);
      if (idx < 5) return AW'(4 + 3 * idx);
      return 8'h16;
   endfunction

   function automatic logic [DW-1:0] ctrl_rst(input int idx);
      case (idx)
         IDX_FUNC: return 8'h41;
         IDX_OTG:  return 8'h06;
         IDX_RISE: return 8'h1F;
         IDX_FALL: return 8'h1F;
         default:  return 8'h00;
      endcase
   endfunction

   function automatic logic [DW-1:0] ctrl_mask(input int idx);
      if (idx == IDX_FUNC) return 8'h7F;
      return 8'hFF;
   endfunction
endpackage

// File: rtl/phyreg_alias_reg.sv
module phyreg_alias_reg
   import phyreg_pkg::*;
#(
   parameter int               RW    = 8,
   parameter int               RAW   = 8,
   parameter logic [RAW-1:0]   BASE  = '0,
   parameter logic [RW-1:0]    RST   = '0,
   parameter logic [RW-1:0]    MASK  = '1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [RAW-1:0] addr,
   input  logic [RW-1:0]  wdata,
   input  logic [RW-1:0]  hw_clr,
   output logic [RW-1:0]  q,
   output logic           hit
);
   localparam int LAST = int'(BASE) + 2;

   if (LAST >= (1 << RAW)) begin : g_bad_base
      $error("alias window runs past the address space");
   end

   logic [RAW-1:0] off;
   alias_op_e      op;
   logic [RW-1:0]  q_n;

   assign off = addr - BASE;
   assign hit = (int'(addr) >= int'(BASE)) && (int'(addr) <= LAST);

   always_comb begin
      op = OP_NONE;
      if (wr_en && hit) begin
         case (off[1:0])
            2'd0:    op = OP_WRITE;
            2'd1:    op = OP_SET;
            default: op = OP_CLEAR;
         endcase
      end
   end

   always_comb begin
      q_n = q & ~hw_clr;
      case (op)
         OP_WRITE: q_n = wdata & MASK;
         OP_SET:   q_n = q_n | (wdata & MASK);
         OP_CLEAR: q_n = q_n & ~wdata;
         default:  ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST & MASK;
      else        q <= q_n;
   end

   AST_SET_ONLY_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SET && hw_clr == '0) |=> ((q & $past(q)) == $past(q))); // R2
   AST_CLEAR_ONLY_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CLEAR) |=> ((q & ~$past(q)) == '0)); // R2
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_NONE && hw_clr == '0) |=> $stable(q)); // R9
endmodule

// File: rtl/phyreg_irq_latch.sv
module phyreg_irq_latch #(
   parameter int N_SRC = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src,
   input  logic [N_SRC-1:0] en_rise,
   input  logic [N_SRC-1:0] en_fall,
   input  logic             rd_clr,
   output logic [N_SRC-1:0] latch_q
);
   logic [N_SRC-1:0] src_d;
   logic [N_SRC-1:0] ev;

   for (genvar b = 0; b < N_SRC; b++) begin : g_edge
      assign ev[b] = (src[b] & ~src_d[b] & en_rise[b]) |
                     (~src[b] & src_d[b] & en_fall[b]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_d   <= '0;
         latch_q <= '0;
      end else begin
         src_d   <= src;
         latch_q <= (rd_clr ? '0 : latch_q) | ev;
      end
   end

   AST_NEW_BIT_NEEDS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((latch_q & ~$past(latch_q) & ~($past(src) ^ $past(src_d))) == '0)); // R5
   AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && ev == '0) |=> (latch_q == '0)); // R6
   AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != '0) |=> ((latch_q & $past(ev)) == $past(ev))); // R6
endmodule

// File: rtl/phyreg_bank.sv
module phyreg_bank
   import phyreg_pkg::*;
#(
   parameter int           N_SRC      = 5,
   parameter int           LS_W       = 2,
   parameter logic [15:0]  VENDOR_ID  = 16'h1A2B,
   parameter logic [15:0]  PRODUCT_ID = 16'h3C4D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_req,
   input  logic             acc_we,
   input  logic [7:0]       acc_addr,
   input  logic [7:0]       acc_wdata,
   output logic [7:0]       acc_rdata,
   output logic             acc_rvalid,
   input  logic [N_SRC-1:0] irq_src,
   input  logic [LS_W-1:0]  line_state,
   input  logic             xcvr_rst_done,
   output logic [7:0]       func_ctrl_o,
   output logic [7:0]       iface_ctrl_o,
   output logic [7:0]       otg_ctrl_o
);
   localparam logic [DW-1:0] EN_MASK   = DW'((32'd1 << N_SRC) - 1);
   localparam logic [DW-1:0] RSTREQ_M  = DW'(32'd1 << RSTREQ_BIT);
   localparam logic [AW-1:0] IMM_LAST  = 8'h3F;

   if (N_SRC > DW || N_SRC < 1) begin : g_bad_src
      $error("source count must fit one data byte");
   end
   if (LS_W > DW || LS_W < 1) begin : g_bad_ls
      $error("line-state width must fit one data byte");
   end

   logic [DW-1:0] ctrl_q   [N_CTRL];
   logic [N_CTRL-1:0] ctrl_hit;
   logic          wr_acc;
   logic          rd_acc;
   logic [DW-1:0] rd_n;
   logic [N_SRC-1:0] lat_q;

   assign wr_acc = acc_req && acc_we;
   assign rd_acc = acc_req && !acc_we;

   for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
      localparam logic [AW-1:0] BASE_I = ctrl_base(i);
      localparam logic [DW-1:0] MASK_I =
         (i == IDX_RISE || i == IDX_FALL) ? EN_MASK : ctrl_mask(i);
      logic [DW-1:0] clr_i;
      if (i == IDX_FUNC) begin : g_hw
         assign clr_i = xcvr_rst_done ? RSTREQ_M : '0;
      end else begin : g_sw
         assign clr_i = '0;
      end
      phyreg_alias_reg #(
         .RW(DW), .RAW(AW), .BASE(BASE_I), .RST(ctrl_rst(i)), .MASK(MASK_I)
      ) u_reg (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .addr(acc_addr),
         .wdata(acc_wdata), .hw_clr(clr_i), .q(ctrl_q[i]), .hit(ctrl_hit[i])
      );
   end

   phyreg_irq_latch #(.N_SRC(N_SRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .src(irq_src),
      .en_rise(ctrl_q[IDX_RISE][N_SRC-1:0]),
      .en_fall(ctrl_q[IDX_FALL][N_SRC-1:0]),
      .rd_clr(rd_acc && acc_addr == A_LATCH),
      .latch_q(lat_q)
   );

   always_comb begin
      rd_n = '0;
      case (acc_addr)
         8'h00:    rd_n = VENDOR_ID[7:0];
         8'h01:    rd_n = VENDOR_ID[15:8];
         8'h02:    rd_n = PRODUCT_ID[7:0];
         8'h03:    rd_n = PRODUCT_ID[15:8];
         A_STATUS: rd_n = DW'(irq_src);
         A_LATCH:  rd_n = DW'(lat_q);
         A_DEBUG:  rd_n = DW'(line_state);
         default:  rd_n = '0;
      endcase
      for (int i = 0; i < N_CTRL; i++) begin
         if (ctrl_hit[i]) rd_n = ctrl_q[i];
      end
      if (acc_addr > IMM_LAST) rd_n = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_rdata  <= '0;
         acc_rvalid <= 1'b0;
      end else begin
         acc_rvalid <= rd_acc;
         if (rd_acc) acc_rdata <= rd_n;
      end
   end

   assign func_ctrl_o  = ctrl_q[IDX_FUNC];
   assign iface_ctrl_o = ctrl_q[IDX_IFACE];
   assign otg_ctrl_o   = ctrl_q[IDX_OTG];

   AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |=> acc_rvalid); // R10
   AST_RSTREQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (func_ctrl_o[RSTREQ_BIT] && !xcvr_rst_done && !wr_acc) |=> func_ctrl_o[RSTREQ_BIT]); // R8
   AST_RSTREQ_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (xcvr_rst_done && !wr_acc) |=> !func_ctrl_o[RSTREQ_BIT]); // R8
   AST_UPPER_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && acc_addr > IMM_LAST) |=> (acc_rdata == '0)); // R9
   AST_ID_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && acc_addr == 8'h00) |=> (acc_rdata == VENDOR_ID[7:0])); // R1
endmodule

// File: tb/phyreg_bank_bench.sv
module phyreg_bank_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] VID = 16'h1A2B;
   localparam logic [15:0] PID = 16'h3C4D;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_req = 1'b0;
   logic       acc_we = 1'b0;
   logic [7:0] acc_addr = '0;
   logic [7:0] acc_wdata = '0;
   logic [7:0] acc_rdata;
   logic       acc_rvalid;
   logic [4:0] irq_src = '0;
   logic [1:0] line_state = '0;
   logic       xcvr_rst_done = 1'b0;
   logic [7:0] func_ctrl_o, iface_ctrl_o, otg_ctrl_o;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phyreg_bank #(.VENDOR_ID(VID), .PRODUCT_ID(PID)) u_phyreg_bank (
      .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .acc_rvalid(acc_rvalid), .irq_src(irq_src), .line_state(line_state),
      .xcvr_rst_done(xcvr_rst_done), .func_ctrl_o(func_ctrl_o),
      .iface_ctrl_o(iface_ctrl_o), .otg_ctrl_o(otg_ctrl_o)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      acc_req = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_req = 1'b0; acc_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      acc_req = 1'b1; acc_we = 1'b0; acc_addr = a;
      @(negedge clk);
      acc_req = 1'b0;
      check("R10 rvalid", {7'd0, acc_rvalid}, 8'h01);
      d = acc_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      check("R3 func out", func_ctrl_o, 8'h41);
      check("R3 otg out", otg_ctrl_o, 8'h06);
      rd_chk("R3 func", 8'h04, 8'h41);
      rd_chk("R3 iface", 8'h07, 8'h00);
      rd_chk("R3 otg", 8'h0A, 8'h06);
      rd_chk("R3 rise", 8'h0D, 8'h1F);
      rd_chk("R3 fall", 8'h10, 8'h1F);
      rd_chk("R3 scratch", 8'h16, 8'h00);
   endtask

   task automatic t_ids;
      rd_chk("R1 vid lo", 8'h00, VID[7:0]);
      rd_chk("R1 vid hi", 8'h01, VID[15:8]);
      rd_chk("R1 pid lo", 8'h02, PID[7:0]);
      rd_chk("R1 pid hi", 8'h03, PID[15:8]);
      wr(8'h00, 8'hAA);
      wr(8'h03, 8'h55);
      rd_chk("R1 vid lo after write", 8'h00, VID[7:0]);
      rd_chk("R1 pid hi after write", 8'h03, PID[15:8]);
   endtask

   task automatic t_alias;
      wr(8'h16, 8'hA5);
      rd_chk("R2 scratch via set alias", 8'h17, 8'hA5);
      wr(8'h17, 8'h0A);
      rd_chk("R2 scratch after set", 8'h16, 8'hAF);
      wr(8'h18, 8'h21);
      rd_chk("R2 scratch after clear", 8'h18, 8'h8E);
      wr(8'h07, 8'h3C);
      check("R10 iface out after write", iface_ctrl_o, 8'h3C);
      rd_chk("R2 iface via clear alias", 8'h09, 8'h3C);
      wr(8'h0B, 8'h80);
      check("R2 otg set alias", otg_ctrl_o, 8'h86);
      wr(8'h0C, 8'h04);
      check("R2 otg clear alias", otg_ctrl_o, 8'h82);
      wr(8'h04, 8'hFF);
      rd_chk("R3 func reserved bit", 8'h05, 8'h7F);
      wr(8'h04, 8'h41);
      wr(8'h0E, 8'hE0);
      rd_chk("R3 rise reserved bits", 8'h0D, 8'h1F);
   endtask

   task automatic t_status;
      logic [7:0] d;
      irq_src = 5'b10101;
      rd_chk("R4 status 10101", 8'h13, 8'h15);
      irq_src = 5'b01010;
      rd_chk("R4 status 01010", 8'h13, 8'h0A);
      irq_src = 5'b00000;
      idle(2);
      rd(8'h14, d);
   endtask

   task automatic t_latch;
      logic [7:0] d;
      wr(8'h0D, 8'h01);
      wr(8'h10, 8'h02);
      rd(8'h14, d);
      @(negedge clk); irq_src = 5'b00011;
      idle(2);
      rd_chk("R5 only enabled rise latched", 8'h14, 8'h01);
      rd_chk("R6 latch cleared by read", 8'h14, 8'h00);
      @(negedge clk); irq_src = 5'b00000;
      idle(2);
      rd_chk("R5 only enabled fall latched", 8'h14, 8'h02);
      rd_chk("R6 latch cleared again", 8'h14, 8'h00);
   endtask

   task automatic t_same_cycle;
      wr(8'h0E, 8'h04);
      @(negedge clk);
      acc_req = 1'b1; acc_we = 1'b0; acc_addr = 8'h14; irq_src = 5'b00100;
      @(negedge clk);
      acc_req = 1'b0;
      check("R6 read returns old latch", acc_rdata, 8'h00);
      rd_chk("R6 same-cycle edge kept", 8'h14, 8'h04);
      rd_chk("R6 cleared after", 8'h14, 8'h00);
   endtask

   task automatic t_debug;
      line_state = 2'b10;
      rd_chk("R7 debug 10", 8'h15, 8'h02);
      line_state = 2'b01;
      rd_chk("R7 debug 01", 8'h15, 8'h01);
   endtask

   task automatic t_rstreq;
      wr(8'h0A, 8'h55);
      wr(8'h16, 8'h3C);
      wr(8'h05, 8'h20);
      check("R8 request set", func_ctrl_o, 8'h61);
      idle(3);
      check("R8 request held", func_ctrl_o, 8'h61);
      @(negedge clk); xcvr_rst_done = 1'b1;
      @(negedge clk); xcvr_rst_done = 1'b0;
      check("R8 request self-cleared", func_ctrl_o, 8'h41);
      rd_chk("R8 otg untouched", 8'h0A, 8'h55);
      rd_chk("R8 scratch untouched", 8'h16, 8'h3C);
      @(negedge clk);
      acc_req = 1'b1; acc_we = 1'b1; acc_addr = 8'h05; acc_wdata = 8'h20;
      xcvr_rst_done = 1'b1;
      @(negedge clk);
      acc_req = 1'b0; acc_we = 1'b0; xcvr_rst_done = 1'b0;
      check("R8 write wins over done", func_ctrl_o, 8'h61);
      wr(8'h06, 8'h20);
   endtask

   task automatic t_reserved;
      wr(8'h2F, 8'hFF);
      rd_chk("R9 indicator reads zero", 8'h2F, 8'h00);
      wr(8'h80, 8'h12);
      rd_chk("R9 vendor space reads zero", 8'h80, 8'h00);
      wr(8'h56, 8'h33);
      rd_chk("R9 aliased upper reads zero", 8'h56, 8'h00);
      rd_chk("R9 0x19 reads zero", 8'h19, 8'h00);
      rd_chk("R9 0x40 reads zero", 8'h40, 8'h00);
      rd_chk("R9 scratch unchanged", 8'h16, 8'h3C);
      check("R9 func unchanged", func_ctrl_o, 8'h41);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset;
      t_ids;
      t_alias;
      t_status;
      t_latch;
      t_same_cycle;
      t_debug;
      t_rstreq;
      t_reserved;
      summary;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary;
   end
endmodule